// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a three-wire serial EEPROM, written as synthesizable logic clocked by a system clock. A host drives a select line, a shift clock and a serial data line. The block oversamples all three, rebuilds each frame and carries out the command it holds. It holds a small word array, 64 words of 16 bits by default. A static strap input chooses whether the host addresses it as 16-bit words or as 8-bit bytes. Read data and ready/busy status return on a serial output that has its own drive enable, so a board-level tri-state buffer can sit on the pin.

A frame is a start bit of 1, a two-bit opcode and an address. Write-type frames also carry data. Opcode 00 is a special group, and the top two address bits pick the command within it. Commands that change the array are gated by a program-enable latch, which is clear after reset. Each such command starts a self-timed program cycle whose length is a parameter given in system-clock cycles. While that cycle runs, the block refuses new frames. A host can poll completion by dropping select and raising it again.

Top module: `eep3w_dev`

## Requirements
- R1: A frame begins with the first 1 sampled on a rising shift-clock edge while select is high. Zeros sampled before it are skipped. The start bit is followed by a two-bit opcode (first bit is the MSB) and then the address, MSB first.
- R2: Opcode 10 reads. On the rising edge that carries the last address bit, the output is enabled and drives 0. On each of the next 16 rising edges (8 in byte mode) it drives the next data bit, MSB first. Reads work whatever the state of the program-enable latch.
- R3: After reset the program-enable latch is clear and every array location reads 0. While the latch is clear, the write, erase, fill and fill-ones commands leave the array unchanged.
- R4: Opcode 00 is the special group, and the two address MSBs choose the command: 11 sets the latch, 00 clears it, 10 is fill-ones and 01 is fill. The latch stays set until a 00 command clears it.
- R5: Opcode 01 writes the data field that follows the address into the addressed location. In byte mode, address bit 0 = 1 selects the upper half (bits 15:8) of word address[6:1], and 0 selects the lower half.
- R6: Opcode 11 sets every bit of the addressed location to 1.
- R7: Fill-ones sets every bit of the array to 1. Fill writes the supplied data pattern to every location.
- R8: An accepted program command keeps the block busy for PROG_CYCLES clocks, starting right after its last bit. Frames sent while busy are ignored.
- R9: If select rises while the block is busy, the output is enabled for as long as select stays high. It drives 0 while busy and 1 once the cycle has finished. If select rises after the cycle has finished, the output stays disabled.
- R10: The output is disabled from the second clock of select low onward. Dropping select part-way through a frame aborts it with no change to the array.
- R11: The address field is 6 bits in word mode (wide_i = 1) and 7 bits in byte mode (wide_i = 0). Byte-mode data fields and reads are 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears the array and the latch |
| sel_i | input | 1 | Device select from the host, active high |
| sclk_i | input | 1 | Serial shift clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| wide_i | input | 1 | Organisation strap: 1 = 16-bit words, 0 = 8-bit bytes |
| sdo_o | output | 1 | Serial read data or ready/busy status |
| sdo_en_o | output | 1 | Drive enable for sdo_o |

## Verification
The bench checks the leading zero bit on reads. A design that leaves it out returns every word shifted by one bit. Byte-mode half selection is checked by reading the same word back in word mode, which exposes swapped halves. The bench issues a program command while the latch is clear, and another while a program cycle is still running. A design that ignores the latch or the busy state corrupts a location that the bench later reads. It also aborts a write halfway through its data and polls status both during and after a program cycle. A design that commits too early, or that reports status after completion, gives a different read value or a driven output where it must be disabled.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
   typedef enum logic [1:0] {
      OP_GROUP = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_OPC, S_ADDR, S_DATA, S_READ, S_DONE
   } st_e;

   typedef enum logic [2:0] {
      C_NONE, C_WORD, C_ERASE, C_ONES, C_FILL
   } cmd_e;
endpackage

// File: rtl/eep3w_timer.sv
module eep3w_timer #(
   parameter int CYCLES = 2000,
   localparam int TW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [TW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             left <= '0;
      else if (start)         left <= TW'(CYCLES);
      else if (left != '0)    left <= left - 1'b1;
   end

   assign busy = (left != '0);

   // R8
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array import eep3w_pkg::*; #(
   parameter int WORDS = 64,
   parameter int WIDTH = 16,
   localparam int AW = $clog2(WORDS),
   localparam int HW = WIDTH / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide,
   input  cmd_e             cmd,
   input  logic [AW:0]      waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW:0]      raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [HW-1:0] rd_l [2];
   logic [AW-1:0] widx, ridx;

   assign widx = wide ? waddr[AW-1:0] : waddr[AW:1];
   assign ridx = wide ? raddr[AW-1:0] : raddr[AW:1];

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [HW-1:0] mem [WORDS];
      logic          hit;
      logic [HW-1:0] ld;

      assign hit = wide | (waddr[0] == 1'(g));
      assign ld  = wide ? wdata[g*HW +: HW] : wdata[HW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
         end else begin
            case (cmd)
               C_WORD:  if (hit) mem[widx] <= ld;
               C_ERASE: if (hit) mem[widx] <= '1;
               C_ONES:  for (int i = 0; i < WORDS; i++) mem[i] <= '1;
               C_FILL:  for (int i = 0; i < WORDS; i++) mem[i] <= ld;
               default: ;
            endcase
         end
      end

      assign rd_l[g] = mem[ridx];
   end

   assign rdata = wide ? {rd_l[1], rd_l[0]}
                       : {(raddr[0] ? rd_l[1] : rd_l[0]), {HW{1'b0}}};
endmodule

// File: rtl/eep3w_ctrl.sv
module eep3w_ctrl import eep3w_pkg::*; #(
   parameter int WORDS = 64,
   parameter int WIDTH = 16,
   localparam int AW = $clog2(WORDS),
   localparam int HW = WIDTH / 2,
   localparam int CW = $clog2(WIDTH + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             sclk,
   input  logic             sdi,
   input  logic             wide,
   input  logic             busy,
   input  logic [WIDTH-1:0] rdata,
   output logic [AW:0]      raddr,
   output cmd_e             cmd,
   output logic [AW:0]      cmd_addr,
   output logic [WIDTH-1:0] cmd_data,
   output logic             sdo,
   output logic             sdo_en
);
   st_e             st;
   op_e             op;
   logic [CW-1:0]   cnt, na, nd;
   logic [AW:0]     addr_sr, addr_nx;
   logic [WIDTH-1:0] data_sr, data_nx;
   logic [WIDTH:0]  out_sr;
   logic            wen, armed, sel_q, sclk_q;
   logic            sclk_rise, sel_rise, busy_any, rd_on, st_on;
   logic [1:0]      sub;

   assign sclk_rise = sel & sclk & ~sclk_q;
   assign sel_rise  = sel & ~sel_q;
   assign busy_any  = busy | (cmd != C_NONE);
   assign na        = wide ? CW'(AW) : CW'(AW + 1);
   assign nd        = wide ? CW'(WIDTH) : CW'(HW);
   assign addr_nx   = {addr_sr[AW-1:0], sdi};
   assign data_nx   = {data_sr[WIDTH-2:0], sdi};
   assign sub       = wide ? addr_nx[AW-1 -: 2] : addr_nx[AW -: 2];
   assign raddr     = addr_nx;
   assign cmd_addr  = addr_sr;
   assign cmd_data  = data_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; op <= OP_GROUP; cnt <= '0; addr_sr <= '0;
         data_sr <= '0; out_sr <= '0; wen <= 1'b0; armed <= 1'b0;
         sel_q <= 1'b0; sclk_q <= 1'b0; cmd <= C_NONE;
      end else begin
         sel_q  <= sel;
         sclk_q <= sclk;
         cmd    <= C_NONE;
         if (!sel) begin
            st    <= S_IDLE;
            armed <= 1'b0;
         end else begin
            if (sel_rise && busy_any) armed <= 1'b1;
            if (sclk_rise) begin
               case (st)
                  S_IDLE: if (sdi && !busy_any && !armed) begin
                     st <= S_OPC; cnt <= '0;
                  end
                  S_OPC: begin
                     op  <= op_e'({op[0], sdi});
                     cnt <= cnt + 1'b1;
                     if (cnt == CW'(1)) begin st <= S_ADDR; cnt <= '0; end
                  end
                  S_ADDR: begin
                     addr_sr <= addr_nx;
                     cnt     <= cnt + 1'b1;
                     if (cnt == na - 1'b1) begin
                        cnt <= '0;
                        st  <= S_DONE;
                        case (op)
                           OP_READ:  begin st <= S_READ; out_sr <= {1'b0, rdata}; end
                           OP_WRITE: st <= S_DATA;
                           OP_ERASE: if (wen) cmd <= C_ERASE;
                           OP_GROUP: case (sub)
                              2'b11:   wen <= 1'b1;
                              2'b00:   wen <= 1'b0;
                              2'b10:   if (wen) cmd <= C_ONES;
                              default: st <= S_DATA;
                           endcase
                        endcase
                     end
                  end
                  S_DATA: begin
                     data_sr <= data_nx;
                     cnt     <= cnt + 1'b1;
                     if (cnt == nd - 1'b1) begin
                        st <= S_DONE;
                        if (wen) cmd <= (op == OP_WRITE) ? C_WORD : C_FILL;
                     end
                  end
                  S_READ: if (cnt == nd) st <= S_DONE;
                          else begin
                             out_sr <= {out_sr[WIDTH-1:0], 1'b0};
                             cnt    <= cnt + 1'b1;
                          end
                  default: ;
               endcase
            end
         end
      end
   end

   assign rd_on  = (st == S_READ);
   assign st_on  = armed & sel;
   assign sdo_en = rd_on | st_on;
   assign sdo    = rd_on ? out_sr[WIDTH] : (st_on & ~busy_any);

   // R10
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !$past(sel)) |-> !sdo_en);
   // R3
   latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != C_NONE) |-> wen);
   // R9
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_on, st_on}));
   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sclk_rise && st == S_IDLE) |=> (st == S_IDLE));
endmodule

// File: rtl/eep3w_dev.sv
module eep3w_dev import eep3w_pkg::*; #(
   parameter int WORDS       = 64,
   parameter int WIDTH       = 16,
   parameter int PROG_CYCLES = 2000,
   localparam int AW = $clog2(WORDS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic wide_i,
   output logic sdo_o,
   output logic sdo_en_o
);
   if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
      $error("WIDTH must be even and at least 4");
   end
   if (WORDS < 4 || (1 << AW) != WORDS) begin : g_bad_depth
      $error("WORDS must be a power of two, at least 4");
   end
   if (PROG_CYCLES < 1) begin : g_bad_cycles
      $error("PROG_CYCLES must be positive");
   end

   cmd_e             cmd;
   logic [AW:0]      raddr, cmd_addr;
   logic [WIDTH-1:0] rdata, cmd_data;
   logic             busy;

   eep3w_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sel(sel_i), .sclk(sclk_i), .sdi(sdi_i),
      .wide(wide_i), .busy(busy), .rdata(rdata), .raddr(raddr),
      .cmd(cmd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .sdo(sdo_o), .sdo_en(sdo_en_o));

   eep3w_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
      .clk(clk), .rst_n(rst_n), .wide(wide_i), .cmd(cmd),
      .waddr(cmd_addr), .wdata(cmd_data), .raddr(raddr), .rdata(rdata));

   eep3w_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(cmd != C_NONE), .busy(busy));
endmodule

// File: tb/sim_eep3w_dev.sv
module sim_eep3w_dev;
   localparam int CLK_P = 10;
   localparam int WORDS = 64;
   localparam int PROG  = 300;
   localparam int AW    = 6;

   logic clk = 0, rst_n = 0, sel = 0, sclk = 0, sdi = 0, wide = 1;
   logic sdo, sdo_en;
   int   n_chk = 0, n_fail = 0, low_cnt = 0;
   logic [15:0] mm [WORDS];
   bit   en = 0;
   bit   done = 0;

   eep3w_dev #(.WORDS(WORDS), .WIDTH(16), .PROG_CYCLES(PROG)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
      .wide_i(wide), .sdo_o(sdo), .sdo_en_o(sdo_en));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // R10: every clock with select low for two clocks, output must be off
   always @(negedge clk) begin
      if (!sel) low_cnt++; else low_cnt = 0;
      if (rst_n && low_cnt >= 2) chk("R10 off while deselected", sdo_en, 0);
   end

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   task automatic tick(input int n); repeat (n) @(negedge clk); endtask
   task automatic pulse(input logic b, output logic o, output logic e);
      sdi = b; tick(2); sclk = 1; tick(3); o = sdo; e = sdo_en; sclk = 0; tick(2);
   endtask
   task automatic sendv(input logic [31:0] v, input int n);
      logic o, e;
      for (int i = n - 1; i >= 0; i--) pulse(v[i], o, e);
   endtask
   task automatic sel_up(); sel = 1; tick(2); endtask
   task automatic sel_dn(); sel = 0; tick(3); endtask
   function automatic int na(); return wide ? AW : AW + 1; endfunction
   function automatic int nd(); return wide ? 16 : 8; endfunction
   function automatic int grp(input int code); return code << (na() - 2); endfunction

   function automatic logic [15:0] mexp(input int a);
      if (wide) return mm[a];
      return a[0] ? {8'h0, mm[a>>1][15:8]} : {8'h0, mm[a>>1][7:0]};
   endfunction
   task automatic mwrite(input int a, input logic [15:0] d, input bit ones);
      logic [15:0] v;
      v = ones ? 16'hFFFF : d;
      if (!en) return;
      if (wide) mm[a] = v;
      else if (a[0]) mm[a>>1][15:8] = v[7:0];
      else mm[a>>1][7:0] = v[7:0];
   endtask
   task automatic mfill(input logic [15:0] d);
      if (!en) return;
      for (int i = 0; i < WORDS; i++) mm[i] = d;
   endtask

   task automatic instr(input logic [1:0] op, input int a, input logic [15:0] d, input bit with_d);
      sel_up();
      sendv({1'b1, op}, 3);
      sendv(a, na());
      if (with_d) sendv(d, nd());
      sel_dn();
   endtask

   task automatic chk_read(input string req, input int a, input int lz);
      logic o, e, ok;
      logic [15:0] w;
      sel_up();
      if (lz > 0) sendv(0, lz);
      sendv(3'b110, 3);
      sendv(a >> 1, na() - 1);
      pulse(a[0], o, e);
      ok = (o === 1'b0) && (e === 1'b1);
      w = 0;
      for (int i = 0; i < nd(); i++) begin
         pulse(0, o, e);
         if (e !== 1'b1) ok = 0;
         w = {w[14:0], o};
      end
      sel_dn();
      chk({req, " dummy/enable"}, ok, 1);
      chk({req, " data"}, w, mexp(a));
   endtask

   initial begin
      logic [15:0] hold9;
      for (int i = 0; i < WORDS; i++) mm[i] = 0;
      tick(3);
      chk("R3 reset output off", sdo_en, 0);
      rst_n = 1;
      tick(3);
      chk("R10 reset idle", sdo_en, 0);

      chk_read("R3 reset contents", 5, 0);
      // R3: write while latch clear is ignored
      instr(2'b01, 5, 16'hA5C3, 1); mwrite(5, 16'hA5C3, 0); tick(PROG + 20);
      chk_read("R3 locked write", 5, 0);

      // R4: unlock, then R5 write
      instr(2'b00, grp(3), 0, 0); en = 1;
      instr(2'b01, 5, 16'hA5C3, 1); mwrite(5, 16'hA5C3, 0); tick(PROG + 20);
      chk_read("R5 word write", 5, 0);

      // R9: status poll while busy, then after finish
      begin
         logic o, e;
         instr(2'b01, 9, 16'h1234, 1); mwrite(9, 16'h1234, 0);
         sel_up(); tick(1);
         chk("R9 busy enable", sdo_en, 1);
         chk("R9 busy level", sdo, 0);
         tick(PROG);
         chk("R9 ready enable", sdo_en, 1);
         chk("R9 ready level", sdo, 1);
         sel_dn(); sel_up(); tick(1);
         chk("R9 no status after finish", sdo_en, 0);
         sel_dn();
         o = 0; e = 0;
      end
      chk_read("R9 written word", 9, 0);

      // R8: frame sent during a program cycle is ignored
      instr(2'b01, 11, 16'h7777, 1); mwrite(11, 16'h7777, 0);
      instr(2'b01, 10, 16'hBEEF, 1);
      tick(PROG + 20);
      chk_read("R8 ignored while busy", 10, 0);
      chk_read("R8 accepted before busy", 11, 0);

      // R6: erase one word
      instr(2'b11, 5, 0, 0); mwrite(5, 0, 1); tick(PROG + 20);
      chk_read("R6 erase word", 5, 0);

      // R10: abort in the middle of the data field
      sel_up(); sendv(3'b101, 3); sendv(9, na()); sendv(8'hFF, 8); sel_dn();
      tick(PROG + 20);
      chk_read("R10 aborted write", 9, 0);

      // R4: lock, then write ignored; R2 read still works while locked
      instr(2'b00, grp(0), 0, 0); en = 0;
      hold9 = mm[9];
      instr(2'b01, 9, 16'h0000, 1); mwrite(9, 0, 0); tick(PROG + 20);
      chk_read("R4 R2 read while locked", 9, 0);
      chk("R4 model unchanged", mm[9], hold9);

      // R7: fill and fill-ones
      instr(2'b00, grp(3), 0, 0); en = 1;
      instr(2'b00, grp(1), 16'h5A5A, 1); mfill(16'h5A5A); tick(PROG + 20);
      chk_read("R7 fill first", 0, 0);
      chk_read("R7 fill last", 63, 0);
      instr(2'b00, grp(2), 0, 0); mfill(16'hFFFF); tick(PROG + 20);
      chk_read("R7 fill-ones", 17, 0);

      // R11: byte mode, R5 half selection
      wide = 0; tick(2);
      instr(2'b01, 15, 16'h003C, 1); mwrite(15, 16'h003C, 0); tick(PROG + 20);
      chk_read("R11 byte upper", 15, 0);
      chk_read("R11 byte lower", 14, 0);
      wide = 1; tick(2);
      chk_read("R5 byte lands in upper half", 7, 0);
      chk("R5 model word", mm[7], 16'h3CFF);

      // R1: leading zeros before the start bit
      chk_read("R1 leading zeros", 7, 3);

      summary();
   end
endmodule